// File: doc/BRIEF.md
# Floating-Point Pipe Occupancy Scheduler

This block decides when the next floating-point instruction may leave the register-access stage and enter a six-stage execution pipe that ends in a single write-back stage. Each instruction carries a class code, a destination tag and two source tags. No arithmetic is performed here. An instruction is a token that moves through the stages one per cycle and retires with a write-back strobe that carries its tag.

Two divide classes keep the write-back stage busy for many cycles. The block records the future write-back cycles in a reservation vector. A new instruction is held only when its own write-back cycles would overlap ones already reserved, so a divide does not block the pipe for its whole duration. A per-register scoreboard counts down the result latency of the class that last targeted each register. Its ready bits gate issue for source reads and for destination reuse, and the upstream bypass network sees them directly.

The upstream stage presents a request with `in_valid`. It keeps the request stable while `stall` is high. The request issues in the first cycle that `stall` is low.

Top module: `fp_pipe_sched`

## Requirements
- R1: After reset every stage is empty, `wb_strobe` is low, every bit of `reg_ready` is 1, and `stall` is low while `in_valid` is low.
- R2: A request issues in cycle c when `in_valid`, `in_ops_ok`, the ready bits of both sources and of the destination are set, and it does not collide in write-back. The instruction is in stage 1 in cycle c+1. It advances one stage per cycle, enters write-back in cycle c+7, and back-to-back issues are allowed.
- R3: `stall` equals `in_valid` and not issued. While `in_ops_ok` is low, a valid request stalls and nothing enters stage 1.
- R4: A request whose source register is not ready stalls until that register's ready bit returns.
- R5: Issue clears the destination's ready bit from cycle c+1. The bit is set again in cycle c+L. L is 5 for class 0 (general arithmetic), 2 for class 1 (condition update), 3 for class 4 (store), and 6 plus the write-back hold for the divides.
- R6: Class 2 (double divide) holds write-back for 25 cycles and class 3 (single divide) for 13. The strobe comes in the last held cycle, c+31 and c+19 respectively.
- R7: A request stalls only if one of its write-back cycles coincides with a reserved one. A general operation following a double divide issued in cycle c issues in cycle c+25, while the divide still holds write-back. A divide directly following a general operation issues without delay.
- R8: A request whose destination register is not ready stalls until it is ready.
- R9: Class codes 5, 6 and 7 behave as general arithmetic: latency 5 and a one-cycle write-back.
- R10: `stage_valid[k-1]` shows the instruction in stage k. The strobe is one cycle wide and `wb_tag` equals the issued destination tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present in register-access stage |
| in_class | input | 3 | Instruction class code |
| in_dst | input | TAGW | Destination register tag |
| in_src_a | input | TAGW | First source register tag |
| in_src_b | input | TAGW | Second source register tag |
| in_ops_ok | input | 1 | Operands from outside the scoreboard are ready |
| stall | output | 1 | Request is held this cycle |
| stage_valid | output | NSTAGES | Occupancy of execution stages 1..NSTAGES |
| wb_strobe | output | 1 | Write-back completes this cycle |
| wb_tag | output | TAGW | Destination tag of the completing instruction |
| reg_ready | output | NREGS | Scoreboard ready bit per register |

## Verification
The hardest case to reach from the ports is a request that issues while a divide still holds write-back. This needs the reservation check to count exactly which future cycles are busy. The bench issues a double divide and presents an independent general operation in the very next cycle. It then measures the cycle in which `stall` first drops, expecting the divide's hold minus nothing else: 25 cycles after the divide. The reverse order, a divide right behind a general operation, shows that a busy pipe alone causes no stall. Destination reuse after a single divide shows the scoreboard wait outlasting the write-back wait.

// File: rtl/fp_pipe_sched_pkg.sv
package fp_pipe_sched_pkg;

  typedef enum logic [2:0] {
    CLS_ARITH = 3'd0,
    CLS_CMP   = 3'd1,
    CLS_DIVD  = 3'd2,
    CLS_DIVS  = 3'd3,
    CLS_STORE = 3'd4
  } fp_class_e;

  // Cycles the class keeps the write-back stage busy.
  function automatic int unsigned wb_hold_of(input logic [2:0] cls,
                                             input int unsigned hold_dd,
                                             input int unsigned hold_ds);
    case (cls)
      CLS_DIVD: return hold_dd;
      CLS_DIVS: return hold_ds;
      default:  return 1;
    endcase
  endfunction

  // Cycles from issue until the destination may be consumed.
  function automatic int unsigned result_lat_of(input logic [2:0] cls,
                                                input int unsigned nstages,
                                                input int unsigned lat_arith,
                                                input int unsigned lat_cmp,
                                                input int unsigned lat_store,
                                                input int unsigned hold_dd,
                                                input int unsigned hold_ds);
    case (cls)
      CLS_CMP:   return lat_cmp;
      CLS_STORE: return lat_store;
      CLS_DIVD:  return nstages + hold_dd;
      CLS_DIVS:  return nstages + hold_ds;
      default:   return lat_arith;
    endcase
  endfunction

endpackage

// File: rtl/fp_wb_resv.sv
module fp_wb_resv #(
  parameter int NSTAGES  = 6,
  parameter int HOLD_MAX = 25,
  parameter int OCCW     = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  logic [OCCW-1:0] req_hold,
  output logic            conflict,
  output logic            busy_now
);
  localparam int ARRIVE = NSTAGES + 1;
  localparam int RW     = ARRIVE + HOLD_MAX;

  // bit i set: write-back is reserved i cycles from now
  logic [RW-1:0] resv_q;
  logic [RW-1:0] new_bits;

  always_comb begin
    conflict = 1'b0;
    new_bits = '0;
    for (int i = 0; i < RW; i++) begin
      if (i >= ARRIVE && i < ARRIVE + int'(req_hold))
        conflict = conflict | resv_q[i];
      if (i >= ARRIVE - 1 && i < ARRIVE - 1 + int'(req_hold))
        new_bits[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resv_q <= '0;
    else        resv_q <= (resv_q >> 1) | (issue ? new_bits : '0);
  end

  assign busy_now = resv_q[0];

endmodule

// File: rtl/fp_scoreboard.sv
module fp_scoreboard #(
  parameter int NREGS = 32,
  parameter int TAGW  = 5,
  parameter int CNTW  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  logic [TAGW-1:0] dst,
  input  logic [CNTW-1:0] lat,
  output logic [NREGS-1:0] ready
);
  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    logic [CNTW-1:0] cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt_q <= '0;
      else if (issue && dst == TAGW'(r))
        cnt_q <= lat - CNTW'(1);
      else if (cnt_q != '0)
        cnt_q <= cnt_q - CNTW'(1);
    end
    assign ready[r] = (cnt_q == '0);
  end

endmodule

// File: rtl/fp_exec_pipe.sv
module fp_exec_pipe #(
  parameter int NSTAGES = 6,
  parameter int TAGW    = 5,
  parameter int OCCW    = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue,
  input  logic [TAGW-1:0]    issue_tag,
  input  logic [OCCW-1:0]    issue_hold,
  output logic [NSTAGES-1:0] stage_valid,
  output logic               wb_strobe,
  output logic [TAGW-1:0]    wb_tag,
  output logic               wb_occupied
);
  logic [NSTAGES-1:0] vld_q;
  logic [TAGW-1:0]    tag_q  [NSTAGES];
  logic [OCCW-1:0]    hold_q [NSTAGES];

  for (genvar s = 0; s < NSTAGES; s++) begin : g_stage
    logic            in_v;
    logic [TAGW-1:0] in_t;
    logic [OCCW-1:0] in_h;
    if (s == 0) begin : g_head
      assign in_v = issue;
      assign in_t = issue_tag;
      assign in_h = issue_hold;
    end else begin : g_body
      assign in_v = vld_q[s-1];
      assign in_t = tag_q[s-1];
      assign in_h = hold_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[s]  <= 1'b0;
        tag_q[s]  <= '0;
        hold_q[s] <= '0;
      end else begin
        vld_q[s]  <= in_v;
        tag_q[s]  <= in_t;
        hold_q[s] <= in_h;
      end
    end
  end

  logic            wb_v_q;
  logic [TAGW-1:0] wb_tag_q;
  logic [OCCW-1:0] wb_left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_v_q    <= 1'b0;
      wb_tag_q  <= '0;
      wb_left_q <= '0;
    end else if (vld_q[NSTAGES-1]) begin
      wb_v_q    <= 1'b1;
      wb_tag_q  <= tag_q[NSTAGES-1];
      wb_left_q <= hold_q[NSTAGES-1];
    end else if (wb_v_q) begin
      if (wb_left_q == OCCW'(1)) wb_v_q <= 1'b0;
      wb_left_q <= wb_left_q - OCCW'(1);
    end
  end

  assign stage_valid = vld_q;
  assign wb_occupied = wb_v_q;
  assign wb_strobe   = wb_v_q && (wb_left_q == OCCW'(1));
  assign wb_tag      = wb_tag_q;

endmodule

// File: rtl/fp_pipe_sched.sv
module fp_pipe_sched
  import fp_pipe_sched_pkg::*;
#(
  parameter int NSTAGES   = 6,
  parameter int NREGS     = 32,
  parameter int LAT_ARITH = 5,
  parameter int LAT_CMP   = 2,
  parameter int LAT_STORE = 3,
  parameter int HOLD_DIVD = 25,
  parameter int HOLD_DIVS = 13,
  localparam int TAGW     = $clog2(NREGS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [2:0]         in_class,
  input  logic [TAGW-1:0]    in_dst,
  input  logic [TAGW-1:0]    in_src_a,
  input  logic [TAGW-1:0]    in_src_b,
  input  logic               in_ops_ok,
  output logic               stall,
  output logic [NSTAGES-1:0] stage_valid,
  output logic               wb_strobe,
  output logic [TAGW-1:0]    wb_tag,
  output logic [NREGS-1:0]   reg_ready
);
  localparam int HOLD_MAX = (HOLD_DIVD > HOLD_DIVS) ? HOLD_DIVD : HOLD_DIVS;
  localparam int MAX_LAT  = NSTAGES + HOLD_MAX;
  localparam int CNTW     = $clog2(MAX_LAT + 1);
  localparam int OCCW     = $clog2(HOLD_MAX + 1);

  logic [OCCW-1:0] req_hold;
  logic [CNTW-1:0] req_lat;
  logic            src_ok;
  logic            wb_conflict;
  logic            issue_fire;
  logic            wb_occupied;
  logic            resv_now;

  assign req_hold = OCCW'(wb_hold_of(in_class, HOLD_DIVD, HOLD_DIVS));
  assign req_lat  = CNTW'(result_lat_of(in_class, NSTAGES, LAT_ARITH, LAT_CMP,
                                        LAT_STORE, HOLD_DIVD, HOLD_DIVS));

  assign src_ok     = reg_ready[in_src_a] & reg_ready[in_src_b] & reg_ready[in_dst];
  assign issue_fire = in_valid & in_ops_ok & src_ok & ~wb_conflict;
  assign stall      = in_valid & ~issue_fire;

  fp_wb_resv #(.NSTAGES(NSTAGES), .HOLD_MAX(HOLD_MAX), .OCCW(OCCW)) resv_i (
    .clk(clk), .rst_n(rst_n), .issue(issue_fire), .req_hold(req_hold),
    .conflict(wb_conflict), .busy_now(resv_now)
  );

  fp_scoreboard #(.NREGS(NREGS), .TAGW(TAGW), .CNTW(CNTW)) sb_i (
    .clk(clk), .rst_n(rst_n), .issue(issue_fire), .dst(in_dst),
    .lat(req_lat), .ready(reg_ready)
  );

  fp_exec_pipe #(.NSTAGES(NSTAGES), .TAGW(TAGW), .OCCW(OCCW)) pipe_i (
    .clk(clk), .rst_n(rst_n), .issue(issue_fire), .issue_tag(in_dst),
    .issue_hold(req_hold), .stage_valid(stage_valid), .wb_strobe(wb_strobe),
    .wb_tag(wb_tag), .wb_occupied(wb_occupied)
  );

endmodule

// File: rtl/fp_pipe_sched_chk.sv
module fp_pipe_sched_chk #(
  parameter int NSTAGES = 6,
  parameter int NREGS   = 32,
  localparam int TAGW   = $clog2(NREGS)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [TAGW-1:0]    in_dst,
  input logic [TAGW-1:0]    in_src_a,
  input logic               stall,
  input logic               issue_fire,
  input logic               wb_conflict,
  input logic               wb_occupied,
  input logic               resv_now,
  input logic               wb_strobe,
  input logic [NSTAGES-1:0] stage_valid,
  input logic [NREGS-1:0]   reg_ready
);
  // R3
  stall_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> in_valid);

  // R2
  issue_enters_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |=> stage_valid[0]);

  // R2
  no_phantom_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_fire |=> !stage_valid[0]);

  for (genvar s = 0; s < NSTAGES - 1; s++) begin : g_adv
    // R10
    stage_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stage_valid[s] |=> stage_valid[s+1]);
  end

  // R7
  wb_no_collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage_valid[NSTAGES-1] |-> (!wb_occupied || wb_strobe));

  // R7
  stall_on_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && wb_conflict) |-> stall);

  // R6
  resv_tracks_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_occupied == resv_now);

  // R5
  issue_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |=> !reg_ready[$past(in_dst)]);

  // R4
  hold_on_busy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !reg_ready[in_src_a]) |-> stall);

endmodule

bind fp_pipe_sched fp_pipe_sched_chk #(.NSTAGES(NSTAGES), .NREGS(NREGS)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst(in_dst),
  .in_src_a(in_src_a), .stall(stall), .issue_fire(issue_fire),
  .wb_conflict(wb_conflict), .wb_occupied(wb_occupied), .resv_now(resv_now),
  .wb_strobe(wb_strobe), .stage_valid(stage_valid), .reg_ready(reg_ready)
);

// File: tb/fp_pipe_sched_tb.sv
module fp_pipe_sched_tb_top;
  localparam int NST  = 6;
  localparam int NR   = 32;
  localparam int TAGW = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [2:0]      in_class = 3'd0;
  logic [TAGW-1:0] in_dst = '0;
  logic [TAGW-1:0] in_src_a = '0;
  logic [TAGW-1:0] in_src_b = '0;
  logic            in_ops_ok = 1'b1;
  logic            stall;
  logic [NST-1:0]  stage_valid;
  logic            wb_strobe;
  logic [TAGW-1:0] wb_tag;
  logic [NR-1:0]   reg_ready;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fp_pipe_sched dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .in_ops_ok(in_ops_ok), .stall(stall), .stage_valid(stage_valid),
    .wb_strobe(wb_strobe), .wb_tag(wb_tag), .reg_ready(reg_ready)
  );

  task automatic chk_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drain();
    repeat (40) @(negedge clk);
  endtask

  // Present a request at a falling edge and wait until it issues.
  task automatic issue_op(input logic [2:0] c, input int d, input int sa,
                          input int sb, output int at);
    in_class = c; in_dst = TAGW'(d); in_src_a = TAGW'(sa); in_src_b = TAGW'(sb);
    in_valid = 1'b1;
    at = -1;
    for (int g = 0; g < 100; g++) begin
      #1;
      if (!stall) begin
        at = cyc;
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic measure(input logic [2:0] c, input int d, input int exp_rdy,
                         input int exp_wb, input string req);
    int n, rdy_at, wb_at, strobes;
    issue_op(c, d, 1, 2, n);
    rdy_at = -1; wb_at = -1; strobes = 0;
    for (int k = 1; k <= 40; k++) begin
      if (k == 1) chk_eq({req, " R5 ready cleared"}, int'(reg_ready[d]), 0);
      if (k <= NST) chk_eq({req, " R10 stage position"}, int'(stage_valid), 1 << (k - 1));
      if (rdy_at < 0 && reg_ready[d]) rdy_at = k;
      if (wb_strobe) begin
        strobes++;
        if (wb_at < 0) begin
          wb_at = k;
          chk_eq({req, " R10 strobe tag"}, int'(wb_tag), d);
        end
      end
      @(negedge clk);
    end
    chk_eq({req, " R5 ready latency"}, rdy_at, exp_rdy);
    chk_eq({req, " write-back cycle"}, wb_at, exp_wb);
    chk_eq({req, " R10 single strobe"}, strobes, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk_eq("R1 stages empty in reset", int'(stage_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk_eq("R1 stages empty", int'(stage_valid), 0);
    chk_eq("R1 no strobe", int'(wb_strobe), 0);
    chk_eq("R1 all ready", int'(&reg_ready), 1);
    chk_eq("R1 no stall when idle", int'(stall), 0);
  endtask

  task automatic t_latencies();
    measure(3'd0, 3, 5, 7, "R2 arith");
    drain();
    measure(3'd1, 4, 2, 7, "R5 compare");
    drain();
    measure(3'd4, 5, 3, 7, "R5 store");
    drain();
    measure(3'd2, 6, 31, 31, "R6 double divide");
    drain();
    measure(3'd3, 7, 19, 19, "R6 single divide");
    drain();
    measure(3'd6, 8, 5, 7, "R9 class 6");
    drain();
  endtask

  task automatic t_ops_flag();
    in_class = 3'd0; in_dst = TAGW'(14); in_src_a = TAGW'(1); in_src_b = TAGW'(2);
    in_ops_ok = 1'b0; in_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk_eq("R3 stall while operands missing", int'(stall), 1);
      @(negedge clk);
      chk_eq("R3 nothing enters stage 1", int'(stage_valid[0]), 0);
    end
    in_ops_ok = 1'b1;
    #1;
    chk_eq("R3 stall drops with operands", int'(stall), 0);
    @(negedge clk);
    in_valid = 1'b0;
    chk_eq("R2 enters stage 1 next cycle", int'(stage_valid[0]), 1);
    drain();
  endtask

  task automatic t_source_dep();
    int n, m;
    issue_op(3'd0, 15, 1, 2, n);
    issue_op(3'd0, 16, 15, 2, m);
    chk_eq("R4 source wait", m - n, 5);
    drain();
  endtask

  task automatic t_dest_reuse();
    int n, m;
    issue_op(3'd3, 17, 1, 2, n);
    issue_op(3'd0, 17, 1, 2, m);
    chk_eq("R8 destination wait", m - n, 19);
    drain();
  endtask

  task automatic t_collision();
    int n, m;
    issue_op(3'd2, 18, 1, 2, n);
    issue_op(3'd0, 19, 1, 2, m);
    chk_eq("R7 issue behind double divide", m - n, 25);
    drain();
  endtask

  task automatic t_no_collision();
    int n, m, p;
    issue_op(3'd0, 20, 1, 2, n);
    issue_op(3'd2, 21, 1, 2, m);
    chk_eq("R7 divide after arith no stall", m - n, 1);
    drain();
    issue_op(3'd0, 22, 1, 2, n);
    issue_op(3'd1, 23, 1, 2, p);
    chk_eq("R2 back-to-back issue", p - n, 1);
    drain();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_latencies();
    t_ops_flag();
    t_source_dep();
    t_dest_reuse();
    t_collision();
    t_no_collision();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule